// File: doc/BRIEF.md
# Open-Drain Line Repeater

The block links two open-drain data lines, one on the host side and one on the card side, into a single half-duplex path that has no direction input. Both lines rest high through their pull-up resistors. Whichever line is pulled low first becomes the master for that transfer. After a programmable edge delay, the block turns on the pull-down of the other (slave) line, so the low level is copied across. When the master releases its line, the block drops the slave pull-down. It then fires a short, timed active pull-up on the slave side to sharpen the rising edge, and returns to rest.

Both line samples pass through two-flop synchronizers before falling-edge detection. While a transfer or its pull-up pulse is in progress, no new master can be chosen. This keeps the block from reacting to the edges it creates itself on the slave line.

A session-enable input from the card sequencer gates everything. With it off, the card line is held low and the host line is left to its resistor.

Top module: `od_link_repeater`

## Requirements
- R1: With `en` high and both lines high, all four drive outputs (`host_pd`, `host_pu`, `card_pd`, `card_pu`) are 0.
- R2: With `en` low, `card_pd` is 1 and `card_pu`, `host_pd`, `host_pu` are 0 whatever the lines do. Dropping `en` during a transfer aborts it at once.
- R3: A falling edge on `host_in` while the block rests asserts `card_pd` exactly 3+EDGE_DLY clock cycles after the line falls (2 synchronizer cycles, 1 decision cycle, EDGE_DLY delay cycles), and not one cycle earlier.
- R4: A falling edge on `card_in` while the block rests asserts `host_pd` after the same 3+EDGE_DLY cycles.
- R5: During a transfer the master side receives neither pull-down nor pull-up, so the copied low never echoes back.
- R6: The slave pull-down is released 3 cycles after the master line rises, in the same cycle the slave pull-up turns on. The pull-up stays on for exactly PU_CYC cycles.
- R7: If both lines fall in the same cycle, the host side is master: `card_pd` is asserted and `host_pd` stays 0.
- R8: A falling edge on the slave line during the pull-up pulse is ignored: no master is chosen from it.
- R9: If the master line returns high before the edge delay expires, the slave is never driven and no pull-up pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Session enable from the card sequencer |
| host_in | input | 1 | Sampled level of the host-side line (asynchronous) |
| card_in | input | 1 | Sampled level of the card-side line (asynchronous) |
| host_pd | output | 1 | Pull-down enable for the host-side line |
| host_pu | output | 1 | Active pull-up pulse enable for the host-side line |
| card_pd | output | 1 | Pull-down enable for the card-side line |
| card_pu | output | 1 | Active pull-up pulse enable for the card-side line |

## Verification
Seeded random transfers pick the master side, the low duration and the idle gap. This separates correct direction choice and exact edge latency from an off-by-one in the delay or pulse counters. Directed cases cover:
- simultaneous falls, which tell the tie-break rule apart from arbitrary choice;
- a slave pulled low during the pull-up pulse, which shows whether the hold-off blocks a spurious master;
- a low shorter than the edge delay, which tells aborting apart from forwarding;
- clearing the enable mid-transfer, which shows the forced card-low state wins over any transfer in progress.

// File: rtl/od_link_repeater.sv
module od_link_repeater #(
  parameter int EDGE_DLY = 4,
  parameter int PU_CYC   = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic host_in,
  input  logic card_in,
  output logic host_pd,
  output logic host_pu,
  output logic card_pd,
  output logic card_pu
);

  localparam int CMAX = (EDGE_DLY > PU_CYC) ? EDGE_DLY : PU_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(EDGE_DLY - 1);
  localparam logic [CW-1:0] PU_LAST  = CW'(PU_CYC - 1);

  typedef enum logic [1:0] {REST, HOLD, DRIVE, BOOST} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic host_mst;
  logic [1:0] hsy, csy;
  logic hq, cq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsy <= 2'b11;
      csy <= 2'b11;
      hq  <= 1'b1;
      cq  <= 1'b1;
    end else begin
      hsy <= {hsy[0], host_in};
      csy <= {csy[0], card_in};
      hq  <= hsy[1];
      cq  <= csy[1];
    end
  end

  wire h_fall = hq & ~hsy[1];
  wire c_fall = cq & ~csy[1];
  wire mst_lvl = host_mst ? hsy[1] : csy[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= REST;
      cnt      <= '0;
      host_mst <= 1'b1;
    end else if (!en) begin
      st  <= REST;
      cnt <= '0;
    end else begin
      case (st)
        REST: begin
          cnt <= '0;
          if (h_fall) begin
            host_mst <= 1'b1;
            st       <= HOLD;
          end else if (c_fall) begin
            host_mst <= 1'b0;
            st       <= HOLD;
          end
        end
        HOLD: begin
          if (mst_lvl) begin
            st  <= REST;
            cnt <= '0;
          end else if (cnt == DLY_LAST) begin
            st  <= DRIVE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        DRIVE: begin
          cnt <= '0;
          if (mst_lvl) st <= BOOST;
        end
        BOOST: begin
          if (cnt == PU_LAST) begin
            st  <= REST;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= REST;
      endcase
    end
  end

  wire drv = en && (st == DRIVE);
  wire bst = en && (st == BOOST);

  assign card_pd = !en || (drv && host_mst);
  assign card_pu = bst && host_mst;
  assign host_pd = drv && !host_mst;
  assign host_pu = bst && !host_mst;

endmodule

// File: rtl/od_link_repeater_chk.sv
module od_link_repeater_chk #(
  parameter int EDGE_DLY = 4,
  parameter int PU_CYC   = 25
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic host_in,
  input logic card_in,
  input logic host_pd,
  input logic host_pu,
  input logic card_pd,
  input logic card_pu
);

  logic [15:0] crun, hrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crun <= '0;
      hrun <= '0;
    end else begin
      crun <= card_pu ? crun + 1'b1 : '0;
      hrun <= host_pu ? hrun + 1'b1 : '0;
    end
  end

  AST_DISABLED_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (card_pd && !card_pu && !host_pd && !host_pu)); // R2

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> !((host_pd || host_pu) && (card_pd || card_pu))); // R5

  AST_PU_AFTER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_pu) |-> $past(card_pd)); // R6

  AST_HPU_AFTER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_pu) |-> $past(host_pd)); // R6

  AST_CPU_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    card_pu |-> (crun < 16'(PU_CYC))); // R6

  AST_HPU_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    host_pu |-> (hrun < 16'(PU_CYC))); // R6

  AST_CPU_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $fell(card_pu)) |-> ($past(crun) == 16'(PU_CYC - 1))); // R6

endmodule

bind od_link_repeater od_link_repeater_chk #(.EDGE_DLY(EDGE_DLY), .PU_CYC(PU_CYC)) chk_i (.*);

// File: tb/od_link_repeater_tb_top.sv
`timescale 1ns/1ps
module od_link_repeater_tb_top;

  localparam int D = 4;
  localparam int P = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic h_ext = 1'b0;
  logic c_ext = 1'b0;
  logic host_pd, host_pu, card_pd, card_pu;
  logic host_in, card_in;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign host_in = !(h_ext || host_pd);
  assign card_in = !(c_ext || card_pd);

  od_link_repeater #(.EDGE_DLY(D), .PU_CYC(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en),
    .host_in(host_in), .card_in(card_in),
    .host_pd(host_pd), .host_pu(host_pu),
    .card_pd(card_pd), .card_pu(card_pu)
  );

  function automatic int fall_lat();
    return 3 + D;
  endfunction

  function automatic int rise_lat();
    return 3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic all_quiet(input string req);
    chk(!host_pd && !host_pu && !card_pd && !card_pu, req,
        {host_pd, host_pu, card_pd, card_pu}, 0);
  endtask

  task automatic xfer(input bit from_host, input int low_len, input int gap);
    bit mst_act = 0;
    string rq = from_host ? "R3" : "R4";
    if (from_host) h_ext = 1'b1; else c_ext = 1'b1;
    for (int i = 1; i <= low_len; i++) begin
      @(negedge clk);
      if (i == fall_lat() - 1)
        chk((from_host ? card_pd : host_pd) == 1'b0, rq, from_host ? card_pd : host_pd, 0);
      if (i == fall_lat())
        chk((from_host ? card_pd : host_pd) == 1'b1, rq, from_host ? card_pd : host_pd, 1);
      if (from_host ? (host_pd || host_pu) : (card_pd || card_pu)) mst_act = 1;
    end
    if (from_host) h_ext = 1'b0; else c_ext = 1'b0;
    for (int i = 1; i <= P + 4; i++) begin
      @(negedge clk);
      if (from_host ? (host_pd || host_pu) : (card_pd || card_pu)) mst_act = 1;
      if (i == rise_lat() - 1)
        chk((from_host ? card_pd : host_pd) && !(from_host ? card_pu : host_pu), "R6",
            from_host ? card_pu : host_pu, 0);
      if (i == rise_lat())
        chk(!(from_host ? card_pd : host_pd) && (from_host ? card_pu : host_pu), "R6",
            from_host ? card_pu : host_pu, 1);
      if (i == rise_lat() + P - 1)
        chk((from_host ? card_pu : host_pu) == 1'b1, "R6", from_host ? card_pu : host_pu, 1);
      if (i == rise_lat() + P)
        chk((from_host ? card_pu : host_pu) == 1'b0, "R6", from_host ? card_pu : host_pu, 0);
    end
    chk(!mst_act, "R5", mst_act, 0);
    cyc(gap);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : stim
    bit seen;
    void'($urandom(32'd20240611));
    cyc(3);
    chk(card_pd && !card_pu && !host_pd && !host_pu, "R2 reset", card_pd, 1);
    @(negedge clk) rst_n = 1'b1;
    cyc(2);
    en = 1'b1;
    cyc(5);
    all_quiet("R1 rest");

    xfer(1'b1, fall_lat() + 5, 6);
    xfer(1'b0, fall_lat() + 5, 6);
    all_quiet("R1 after transfers");

    // R7 simultaneous falls
    h_ext = 1'b1; c_ext = 1'b1;
    cyc(fall_lat());
    chk(card_pd && !host_pd, "R7", {card_pd, host_pd}, 2);
    cyc(3);
    h_ext = 1'b0;
    cyc(rise_lat());
    chk(card_pu && !host_pd && !host_pu, "R7", card_pu, 1);
    cyc(P + 4);
    c_ext = 1'b0;
    cyc(6);
    all_quiet("R1 after tie");

    // R8 slave falls during pull-up pulse
    h_ext = 1'b1;
    cyc(fall_lat() + 3);
    h_ext = 1'b0;
    cyc(rise_lat());
    c_ext = 1'b1;
    seen = 0;
    for (int i = 0; i < P + 10; i++) begin
      @(negedge clk);
      if (host_pd) seen = 1;
    end
    chk(!seen, "R8", seen, 0);
    c_ext = 1'b0;
    cyc(6);

    // R9 low shorter than edge delay
    h_ext = 1'b1;
    cyc(2);
    h_ext = 1'b0;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (card_pd || card_pu) seen = 1;
    end
    chk(!seen, "R9", seen, 0);

    // R2 line activity with enable off
    en = 1'b0;
    h_ext = 1'b1;
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!card_pd || card_pu || host_pd || host_pu) seen = 1;
    end
    chk(!seen, "R2 disabled", seen, 0);
    h_ext = 1'b0;
    cyc(4);
    en = 1'b1;
    cyc(6);
    all_quiet("R1 after enable");

    // R2 abort mid-transfer
    c_ext = 1'b1;
    cyc(fall_lat() + 2);
    chk(host_pd, "R4", host_pd, 1);
    en = 1'b0;
    #0.5;
    chk(card_pd && !host_pd && !host_pu && !card_pu, "R2 abort", host_pd, 0);
    cyc(3);
    c_ext = 1'b0;
    cyc(3);
    en = 1'b1;
    cyc(6);
    all_quiet("R1 after abort");

    for (int k = 0; k < 40; k++)
      xfer(1'($urandom_range(0, 1)), fall_lat() + 1 + int'($urandom_range(0, 30)),
           4 + int'($urandom_range(0, 10)));
    all_quiet("R1 end");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule